// File: doc/BRIEF.md
# Pulse-Rate Serial Bit Receiver with Codeword Check

This block turns the pulse rate of a toggling input into a serial bit stream. The input is synchronized into the clock domain and its rising edges are counted over fixed windows of a programmable number of clocks. Each window yields one bit: a count above a programmable threshold is a one, anything else is a zero. The window timer runs freely from reset, and the sender uses the same window length.

The decided bits are searched for a start pattern. Once the pattern is found, the next windows fill a codeword made of a data field and an 8-bit check value. The check value is recomputed over the data bits as they arrive, and the whole codeword is judged in one step. A match presents the data with a one-cycle valid strobe. A mismatch gives a one-cycle error strobe, which an external controller can use to request the transmission again. Either way the block goes back to searching for the start pattern.

Top module: `freq_bit_rx`

## Requirements
- R1: A window lasts `periodCfg` clocks. The first window starts at the first clock edge after reset is released. A new `periodCfg` value applied on a window boundary sets the length of the next window.
- R2: A window whose rising-edge count is strictly greater than `thresholdCfg` decides a 1. A count equal to or below it decides a 0.
- R3: The per-window edge counter saturates at its all-ones value (15 for `CNT_W`=4) and does not wrap. With 20 edges and a threshold of 10, the window decides a 1.
- R4: A rising edge of `pulseIn` that is first sampled high at clock edge k is counted at edge k+2. It belongs to the window that ends at edge k+2 if that edge is the window's last one; otherwise it belongs to the next window.
- R5: The start pattern is the bit sequence 1,0,1,0,1,0,1,1 (0xAB, first bit received as MSB), matched on a sliding basis over the decided bits, overlapping prefixes included. Without this pattern, no strobe is ever produced.
- R6: After a match, the next `DATA_W`+8 windows form the codeword: data MSB first, then the check value MSB first. The check value is the CRC over the data bits with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, no reflection and no final XOR.
- R7: When the received check value equals the recomputed one, `dataValid` is high for exactly one clock and `dataOut` carries the data field.
- R8: When they differ, including a single flipped data or check bit, `crcError` is high for exactly one clock and `dataOut` keeps its previous value.
- R9: After either outcome the block searches for a fresh start pattern. Bits from the earlier match are not reused.
- R10: During and right after reset, `dataOut` is 0 and `dataValid` and `crcError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous pulse train whose rate encodes the bit |
| periodCfg | input | PERIOD_W | Window length in clocks (at least 3) |
| thresholdCfg | input | CNT_W | Edge count at or below which a window decides 0 |
| dataOut | output | DATA_W | Data field of the last accepted codeword |
| dataValid | output | 1 | One-cycle strobe for an accepted codeword |
| crcError | output | 1 | One-cycle strobe for a rejected codeword |

## Verification
The window end and an incoming counted edge can fall on the same clock. The one-cycle gap that drives the final judgement to a specific count lands in exactly that clock. The bench provokes this by raising the pulse two clocks before a window's last edge, so it must join the closing window. It also raises the pulse one clock later, so it must spill into the next window. Both placements are used inside a full codeword whose bit counts sit one away from the threshold. Any misassignment of a boundary edge therefore flips a decided bit and shows up as a wrong data word or a false error strobe.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CRC_W-1:0] CRC_INIT = 8'h00;
  localparam logic [7:0] START_PATTERN = 8'hAB;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_CHECK   = 2'd2
  } rxState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftPre;   // push decided bit into start-pattern shifter
    logic startWord;  // pattern seen: clear shifter and running CRC
    logic shiftWord;  // push decided bit into codeword register
    logic crcEn;      // bit belongs to the data field
    logic commit;     // judge the codeword
  } rxCtl_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur, input logic din);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = cur[CRC_W-1] ^ din;
    nxt = {cur[CRC_W-2:0], 1'b0};
    if (fb) nxt = nxt ^ CRC_POLY;
    return nxt;
  endfunction

endpackage

// File: rtl/fbr_window_counter.sv
module fbr_window_counter #(
  parameter int PERIOD_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pulseIn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [CNT_W-1:0]    thresholdCfg,
  output logic                bitStrobe,
  output logic                bitValue
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PERIOD_W:0] TMR_ONE = {{PERIOD_W{1'b0}}, 1'b1};

  logic syncA, syncB, syncC;
  logic edgeSeen;
  logic [PERIOD_W-1:0] timer;
  logic [PERIOD_W:0]   timerInc;
  logic windowEnd;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] cntSum;

  // two-flop synchronizer plus one delay stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= pulseIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeSeen  = syncB & ~syncC;
  assign timerInc  = {1'b0, timer} + TMR_ONE;
  assign windowEnd = (timerInc >= {1'b0, periodCfg});
  assign cntSum    = (edgeSeen && (edgeCnt != CNT_MAX)) ? edgeCnt + CNT_ONE : edgeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer     <= '0;
      edgeCnt   <= '0;
      bitStrobe <= 1'b0;
      bitValue  <= 1'b0;
    end else if (windowEnd) begin
      timer     <= '0;
      edgeCnt   <= '0;
      bitStrobe <= 1'b1;
      bitValue  <= (cntSum > thresholdCfg);
    end else begin
      timer     <= timerInc[PERIOD_W-1:0];
      edgeCnt   <= cntSum;
      bitStrobe <= 1'b0;
    end
  end

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == CNT_MAX && !windowEnd) |=> (edgeCnt == CNT_MAX));

  p_window_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    windowEnd |=> (timer == '0 && edgeCnt == '0));

  p_strobe_follows_end_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> $past(windowEnd));

endmodule

// File: rtl/fbr_control.sv
module fbr_control
  import fbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitStrobe,
  input  logic   preambleHit,
  output rxCtl_t ctl
);

  localparam int TOTAL = DATA_W + CRC_W;
  localparam int BW    = $clog2(TOTAL);
  localparam logic [BW-1:0] LAST_IDX = BW'(TOTAL - 1);
  localparam logic [BW-1:0] DATA_END = BW'(DATA_W);
  localparam logic [BW-1:0] IDX_ONE  = BW'(1);

  rxState_t state;
  logic [BW-1:0] bitCnt;

  always_comb begin
    ctl = '0;
    case (state)
      ST_HUNT: begin
        ctl.shiftPre  = bitStrobe;
        ctl.startWord = preambleHit;
      end
      ST_COLLECT: begin
        ctl.shiftWord = bitStrobe;
        ctl.crcEn     = bitStrobe && (bitCnt < DATA_END);
      end
      ST_CHECK: begin
        ctl.commit = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          bitCnt <= '0;
          if (preambleHit) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (bitStrobe) begin
            if (bitCnt == LAST_IDX) begin
              state  <= ST_CHECK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + IDX_ONE;
            end
          end
        end
        ST_CHECK: state <= ST_HUNT;
        default:  state <= ST_HUNT;
      endcase
    end
  end

  p_enter_collect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && preambleHit) |=> (state == ST_COLLECT));

  p_bitcnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_IDX);

  p_check_returns_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK) |=> (state == ST_HUNT));

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValue,
  input  rxCtl_t            ctl,
  output logic              preambleHit,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              crcError
);

  localparam int TOTAL = DATA_W + CRC_W;

  logic [7:0]       preSr;
  logic [TOTAL-1:0] word;
  logic [CRC_W-1:0] crcRun;

  assign preambleHit = (preSr == START_PATTERN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preSr <= '0;
    end else if (ctl.startWord || ctl.commit) begin
      preSr <= '0;
    end else if (ctl.shiftPre) begin
      preSr <= {preSr[6:0], bitValue};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word   <= '0;
      crcRun <= CRC_INIT;
    end else if (ctl.startWord) begin
      word   <= '0;
      crcRun <= CRC_INIT;
    end else if (ctl.shiftWord) begin
      word <= {word[TOTAL-2:0], bitValue};
      if (ctl.crcEn) crcRun <= crcStep(crcRun, bitValue);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      crcError  <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      crcError  <= 1'b0;
      if (ctl.commit) begin
        if (crcRun == word[CRC_W-1:0]) begin
          dataValid <= 1'b1;
          dataOut   <= word[TOTAL-1:CRC_W];
        end else begin
          crcError <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  p_error_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    crcError |=> !crcError);

  p_dataout_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    crcError |-> $stable(dataOut));

  p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> !preambleHit);

  p_strobes_after_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid || crcError) |-> $past(ctl.commit));

endmodule

// File: rtl/freq_bit_rx.sv
module freq_bit_rx
  import fbr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PERIOD_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pulseIn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [CNT_W-1:0]    thresholdCfg,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataValid,
  output logic                crcError
);

  logic   bitStrobe;
  logic   bitValue;
  logic   preambleHit;
  rxCtl_t ctl;

  fbr_window_counter #(.PERIOD_W(PERIOD_W), .CNT_W(CNT_W)) winCnt_i (
    .clk          (clk),
    .rstN         (rstN),
    .pulseIn      (pulseIn),
    .periodCfg    (periodCfg),
    .thresholdCfg (thresholdCfg),
    .bitStrobe    (bitStrobe),
    .bitValue     (bitValue)
  );

  fbr_control #(.DATA_W(DATA_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .bitStrobe   (bitStrobe),
    .preambleHit (preambleHit),
    .ctl         (ctl)
  );

  fbr_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .bitValue    (bitValue),
    .ctl         (ctl),
    .preambleHit (preambleHit),
    .dataOut     (dataOut),
    .dataValid   (dataValid),
    .crcError    (crcError)
  );

  p_result_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataValid, crcError}));

endmodule

// File: tb/freq_bit_rx_tb.sv
`timescale 1ns/1ps
module freq_bit_rx_tb_top;

  localparam int DATA_W = 16;
  localparam int PW     = 8;
  localparam int CW     = 4;

  logic clk = 1'b0;
  logic rstN;
  logic pulseIn;
  logic [PW-1:0] periodCfg;
  logic [CW-1:0] thresholdCfg;
  logic [DATA_W-1:0] dataOut;
  logic dataValid;
  logic crcError;

  always #2.5 clk = ~clk;

  freq_bit_rx #(.DATA_W(DATA_W), .PERIOD_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .periodCfg(periodCfg),
    .thresholdCfg(thresholdCfg), .dataOut(dataOut), .dataValid(dataValid),
    .crcError(crcError)
  );

  int checks = 0;
  int errors = 0;
  int validCnt = 0;
  int errCnt = 0;
  logic [DATA_W-1:0] lastData = '0;
  int curPeriod = 64;
  logic done = 1'b0;

  typedef struct packed {
    logic [15:0] data;
    logic [23:0] flip;
    logic [4:0]  onesP;
    logic [1:0]  onesLate;
    logic [4:0]  zerosP;
    logic [1:0]  zerosLate;
    logic [3:0]  thr;
    logic [7:0]  period;
    logic        expOk;
  } vec_t;

  // late: 0 none, 1 edge lands on the window's last clock, 2 edge spills to next window
  localparam vec_t VECS [8] = '{
    '{16'h1234, 24'h000000, 5'd6,  2'd0, 5'd2, 2'd0, 4'd4,  8'd64, 1'b1},
    '{16'hBEEF, 24'h000001, 5'd6,  2'd0, 5'd2, 2'd0, 4'd4,  8'd64, 1'b0},
    '{16'h0F0F, 24'h000000, 5'd5,  2'd0, 5'd4, 2'd0, 4'd4,  8'd64, 1'b1},
    '{16'hFFFF, 24'h000000, 5'd20, 2'd0, 5'd2, 2'd0, 4'd10, 8'd64, 1'b1},
    '{16'h5A3C, 24'h000000, 5'd4,  2'd1, 5'd3, 2'd2, 4'd4,  8'd64, 1'b1},
    '{16'hA5C3, 24'h000000, 5'd6,  2'd0, 5'd2, 2'd0, 4'd4,  8'd40, 1'b1},
    '{16'h8001, 24'h800000, 5'd6,  2'd0, 5'd2, 2'd0, 4'd4,  8'd40, 1'b0},
    '{16'h7E81, 24'h000000, 5'd6,  2'd0, 5'd2, 2'd0, 4'd4,  8'd64, 1'b1}
  };

  function automatic logic [7:0] refCrc(input logic [15:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (dataValid) begin
        validCnt++;
        lastData = dataOut;
      end
      if (crcError) errCnt++;
    end
  end

  // starts at a negedge just before a window's first edge, ends likewise
  task automatic sendWindow(input int pulses, input int late);
    for (int j = 0; j < curPeriod; j++) begin
      logic v;
      v = 1'b0;
      for (int i = 0; i < pulses; i++) if (j == 4 + 2 * i) v = 1'b1;
      if (late == 1 && (j == curPeriod - 3 || j == curPeriod - 2)) v = 1'b1;
      if (late == 2 && (j == curPeriod - 2 || j == curPeriod - 1)) v = 1'b1;
      pulseIn = v;
      @(negedge clk);
    end
  endtask

  task automatic sendFrame(input vec_t vv);
    logic [11:0] lead;
    logic [23:0] cw;
    lead = 12'b1010_10101011;
    cw = {vv.data, refCrc(vv.data)} ^ vv.flip;
    for (int i = 11; i >= 0; i--)
      if (lead[i]) sendWindow(int'(vv.onesP), int'(vv.onesLate));
      else         sendWindow(int'(vv.zerosP), int'(vv.zerosLate));
    for (int i = 23; i >= 0; i--)
      if (cw[i]) sendWindow(int'(vv.onesP), int'(vv.onesLate));
      else       sendWindow(int'(vv.zerosP), int'(vv.zerosLate));
    sendWindow(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vBefore;
    int eBefore;
    logic [DATA_W-1:0] prevData;
    rstN = 1'b0;
    pulseIn = 1'b0;
    periodCfg = PW'(64);
    thresholdCfg = CW'(4);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(dataOut == '0, "R10 dataOut", dataOut, 0);
    check(!dataValid && !crcError, "R10 strobes", {dataValid, crcError}, 0);
    rstN = 1'b1;

    // R5 no start pattern: zeros then a near miss 10101010
    for (int k = 0; k < 10; k++) sendWindow(2, 0);
    for (int k = 0; k < 8; k++) sendWindow((k % 2 == 0) ? 6 : 2, 0);
    for (int k = 0; k < 30; k++) sendWindow(2, 0);
    check(validCnt == 0 && errCnt == 0, "R5 no strobe without pattern", validCnt + errCnt, 0);

    // table walk: R1 R2 R3 R4 R6 R7 R8 R9
    for (int v = 0; v < 8; v++) begin
      curPeriod = int'(VECS[v].period);
      periodCfg = VECS[v].period;
      thresholdCfg = VECS[v].thr;
      vBefore = validCnt;
      eBefore = errCnt;
      prevData = lastData;
      sendFrame(VECS[v]);
      if (VECS[v].expOk) begin
        check(validCnt == vBefore + 1, "R7 valid strobe count", validCnt - vBefore, 1);
        check(errCnt == eBefore, "R6 no error on good codeword", errCnt - eBefore, 0);
        check(dataOut == VECS[v].data, "R2 R6 R7 dataOut", dataOut, VECS[v].data);
      end else begin
        check(errCnt == eBefore + 1, "R8 error strobe count", errCnt - eBefore, 1);
        check(validCnt == vBefore, "R8 no valid on bad codeword", validCnt - vBefore, 0);
        check(dataOut == prevData, "R8 dataOut held", dataOut, prevData);
      end
    end

    // R9: codeword bits without a fresh pattern produce nothing
    vBefore = validCnt;
    eBefore = errCnt;
    for (int i = 23; i >= 0; i--) begin
      logic [23:0] cw;
      cw = {16'h1234, refCrc(16'h1234)};
      sendWindow(cw[i] ? 6 : 2, 0);
    end
    for (int k = 0; k < 4; k++) sendWindow(2, 0);
    check(validCnt == vBefore && errCnt == eBefore, "R9 no reuse of old match",
          (validCnt - vBefore) + (errCnt - eBefore), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule